// File: doc/BRIEF.md
# Per-Slot Audio Level Violation Monitor

This block watches a stream of two's-complement audio samples, each tagged with a 5-bit time-slot index. It looks only at the upper byte of each sample and takes that byte's magnitude, so the sign plays no part. It compares the magnitude against a programmable 7-bit ceiling. When the magnitude is above the ceiling, a sticky flag for that sample's time slot is set.

The 32 flags are split evenly between two slot-list sequencers: 16 slots for the first list and 16 for the second. Software sees all 32 flags as one report word. A read strobe from the register decoder marks the cycle in which software samples the word. The block then clears every flag on the following clock edge. A violation that arrives in that same cycle still survives the clear.

Top module: `lvl_report_monitor`

## Requirements
- R1: After reset, `report` is all zeros.
- R2: A valid sample whose upper byte is positive with a value above `max_level` sets bit `smp_slot` of `report` on the next clock edge.
- R3: A negative upper byte is judged by its absolute value. For example, byte 0xCE (-50) violates when `max_level` is 49, and does not violate when `max_level` is 50.
- R4: A magnitude equal to `max_level` is not a violation; only a strictly greater magnitude counts.
- R5: Byte 0x80 (-128) has magnitude 128, so it is a violation for every `max_level`, including 127.
- R6: With `max_level` set to 0, any nonzero byte violates and byte 0x00 does not.
- R7: A set bit stays set through any later samples, violating or not, until a read.
- R8: While `rd_strobe` is high, `report` shows the accumulated flags. On the clock edge that ends the read cycle, all 32 bits clear to zero.
- R9: A violation presented in the same cycle as `rd_strobe` is not lost. After the clear, only that slot's bit is set.
- R10: Slot indices 0 to 15 (first list) map to report bits 0 to 15, and indices 16 to 31 (second list) map to bits 16 to 31. A violation changes only its own bit.
- R11: When `smp_valid` is low, the sample inputs have no effect on `report`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_byte | input | 8 | Upper byte of the sample, two's complement |
| smp_slot | input | 5 | Time-slot index of the sample |
| max_level | input | 7 | Violation ceiling, 0 to 127 |
| rd_strobe | input | 1 | Report read in this cycle; clears after the edge |
| report | output | 32 | Sticky per-slot violation flags |

## Verification
The bench goes after the compare boundary on both signs. A design that used `>=` would flag a magnitude equal to the ceiling. A design that ignored the sign bit would miss negative peaks, or would flag small negative bytes as huge values. The bench also probes byte -128 at ceiling 127. A magnitude computed in 7 bits wraps to 0 there and hides the worst peak. It drives a violation in the very cycle of a read, which catches a clear that has priority over a set. Finally, it sweeps the slot index across the list boundary, so an off-by-one or a swapped half in the bit mapping shows up as a wrong bit.

// File: rtl/lvlmon_pkg.sv
package lvlmon_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LEVEL_W    = 7;
  localparam int unsigned NUM_LISTS  = 2;
  localparam int unsigned LIST_SLOTS = 16;
  localparam int unsigned NUM_SLOTS  = NUM_LISTS * LIST_SLOTS;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);

  // Absolute value of a two's-complement byte; -128 yields 128 (unsigned).
  function automatic logic [BYTE_W-1:0] byte_mag(input logic [BYTE_W-1:0] b);
    if (b[BYTE_W-1]) return (~b) + {{(BYTE_W-1){1'b0}}, 1'b1};
    else             return b;
  endfunction

  // Strictly-greater test of magnitude against a ceiling.
  function automatic logic over_level(input logic [BYTE_W-1:0] mag,
                                      input logic [LEVEL_W-1:0] lvl);
    return mag > {{(BYTE_W-LEVEL_W){1'b0}}, lvl};
  endfunction
endpackage

// File: rtl/lvlmon_mag_cmp.sv
module lvlmon_mag_cmp
  import lvlmon_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [LEVEL_W-1:0] level_in,
  output logic [BYTE_W-1:0]  mag_out,
  output logic               over_out
);
  always_comb begin
    mag_out  = byte_mag(byte_in);
    over_out = over_level(mag_out, level_in);
  end
endmodule

// File: rtl/lvlmon_slot_decode.sv
module lvlmon_slot_decode #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             fire,
  input  logic [IDX_W-1:0] idx,
  output logic [SLOTS-1:0] hit_vec
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign hit_vec[g] = fire && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/lvlmon_flag_bank.sv
module lvlmon_flag_bank #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] set_vec,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] keep;

  // Sets win over the read clear so no violation is lost.
  always_comb keep = clr ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= keep | set_vec;
  end
endmodule

// File: rtl/lvl_report_monitor.sv
module lvl_report_monitor
  import lvlmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [BYTE_W-1:0]    smp_byte,
  input  logic [SLOT_W-1:0]    smp_slot,
  input  logic [LEVEL_W-1:0]   max_level,
  input  logic                 rd_strobe,
  output logic [NUM_SLOTS-1:0] report
);
  logic [BYTE_W-1:0]    smp_mag;
  logic                 smp_over;
  logic                 viol_fire;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic                 hit_any;

  lvlmon_mag_cmp u_cmp (
    .byte_in  (smp_byte),
    .level_in (max_level),
    .mag_out  (smp_mag),
    .over_out (smp_over)
  );

  assign viol_fire = smp_valid && smp_over;

  lvlmon_slot_decode #(.SLOTS(NUM_SLOTS)) u_dec (
    .fire    (viol_fire),
    .idx     (smp_slot),
    .hit_vec (hit_vec)
  );

  assign hit_any = |hit_vec;

  for (genvar l = 0; l < NUM_LISTS; l++) begin : g_list
    lvlmon_flag_bank #(.WIDTH(LIST_SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rd_strobe),
      .set_vec (hit_vec[l*LIST_SLOTS +: LIST_SLOTS]),
      .flags   (report[l*LIST_SLOTS +: LIST_SLOTS])
    );
  end
endmodule

// File: rtl/lvl_report_monitor_chk.sv
module lvl_report_monitor_chk
  import lvlmon_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic [BYTE_W-1:0]    smp_byte,
  input logic [LEVEL_W-1:0]   max_level,
  input logic                 rd_strobe,
  input logic [NUM_SLOTS-1:0] report,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic                 hit_any
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> report == '0);

  a_r10_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r4_equal_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_byte == {1'b0, max_level}) |-> !hit_any);

  a_r5_min_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_byte == 8'h80) |-> hit_any);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((report & $past(report)) == $past(report)));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !hit_any) |=> report == '0);

  a_r9_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && hit_any) |=> report == $past(hit_vec));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe && !smp_valid) |=> $stable(report));
endmodule

bind lvl_report_monitor lvl_report_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_byte  (smp_byte),
  .max_level (max_level),
  .rd_strobe (rd_strobe),
  .report    (report),
  .hit_vec   (hit_vec),
  .hit_any   (hit_any)
);

// File: tb/lvl_report_monitor_tb_top.sv
`timescale 1ns/1ps
module lvl_report_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_byte = '0;
  logic [4:0]  smp_slot = '0;
  logic [6:0]  max_level = '0;
  logic        rd_strobe = 1'b0;
  logic [31:0] report;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] exp_rep = '0;

  always #2.5 clk = ~clk;

  lvl_report_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .smp_slot(smp_slot), .max_level(max_level), .rd_strobe(rd_strobe),
    .report(report)
  );

  // Bench-side violation rule, written as integer arithmetic.
  function automatic bit model_viol(input logic [7:0] b, input logic [6:0] lvl);
    int v;
    v = $signed(b);
    if (v < 0) v = -v;
    return v > int'(lvl);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: report=%h expected=%h", req, act, exp);
    end
  endtask

  // One sample cycle; result checked one edge later.
  task automatic send(input string req, input int slot, input logic [7:0] b,
                      input logic [6:0] lvl, input bit vld);
    @(negedge clk);
    smp_valid = vld; smp_byte = b; smp_slot = 5'(slot); max_level = lvl;
    if (vld && model_viol(b, lvl)) exp_rep[slot] = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    check(req, report, exp_rep);
  endtask

  task automatic do_read(input string req, input bit with_hit, input int slot,
                         input logic [7:0] b, input logic [6:0] lvl);
    @(negedge clk);
    rd_strobe = 1'b1;
    smp_valid = with_hit; smp_byte = b; smp_slot = 5'(slot); max_level = lvl;
    #1 check({req, " read value"}, report, exp_rep);
    exp_rep = '0;
    if (with_hit && model_viol(b, lvl)) exp_rep[slot] = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; smp_valid = 1'b0;
    check({req, " after clear"}, report, exp_rep);
  endtask

  task automatic t_reset();
    check("R1 reset", report, 32'h0);
  endtask

  task automatic t_positive();
    send("R2 pos above", 3, 8'd60, 7'd59, 1'b1);
    send("R2 pos below", 4, 8'd20, 7'd59, 1'b1);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_negative();
    send("R3 neg over", 5, 8'hCE, 7'd49, 1'b1);
    send("R3 neg equal", 6, 8'hCE, 7'd50, 1'b1);
    send("R3 small neg", 7, 8'hFF, 7'd10, 1'b1);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_equal();
    send("R4 equal", 8, 8'd100, 7'd100, 1'b1);
    send("R4 one over", 9, 8'd101, 7'd100, 1'b1);
    send("R4 max equal", 10, 8'd127, 7'd127, 1'b1);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_min_byte();
    send("R5 minus128", 11, 8'h80, 7'd127, 1'b1);
    check("R5 bit set", report, 32'h0000_0800);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_zero_level();
    send("R6 zero byte", 12, 8'h00, 7'd0, 1'b1);
    send("R6 plus one", 13, 8'h01, 7'd0, 1'b1);
    send("R6 minus one", 14, 8'hFF, 7'd0, 1'b1);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_sticky();
    send("R7 set", 20, 8'd90, 7'd10, 1'b1);
    send("R7 quiet same slot", 20, 8'd1, 7'd10, 1'b1);
    send("R7 quiet other", 21, 8'd2, 7'd10, 1'b1);
    check("R7 held", report, 32'h0010_0000);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_read_hit();
    send("R9 pre", 1, 8'd70, 7'd5, 1'b1);
    do_read("R9 read+hit", 1'b1, 30, 8'h85, 7'd5);
    check("R9 only new bit", report, 32'h4000_0000);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_mapping();
    for (int s = 0; s < 32; s++) begin
      send("R10 map", s, 8'h90, 7'd3, 1'b1);
      check("R10 bit pattern", report, (32'h1 << (s + 1)) - 32'h1);
    end
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
    send("R10 slot15", 15, 8'd50, 7'd3, 1'b1);
    check("R10 slot15 list1", report, 32'h0000_8000);
    send("R10 slot16", 16, 8'd50, 7'd3, 1'b1);
    check("R10 slot16 list2", report, 32'h0001_8000);
    do_read("R8 read", 1'b0, 0, 8'h0, 7'd0);
  endtask

  task automatic t_invalid();
    send("R11 invalid", 2, 8'h80, 7'd0, 1'b0);
    send("R11 invalid hi", 31, 8'd127, 7'd0, 1'b0);
    check("R11 no effect", report, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_equal();
    t_min_byte();
    t_zero_level();
    t_sticky();
    t_read_hit();
    t_mapping();
    t_invalid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: ran=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule